// File: doc/BRIEF.md
# Power Mode Clock Gating Controller

This block holds the power mode of a small processing subsystem and drives the clock enables of its domains: the CPU core, the memory, a group of always-on peripherals and a group of peripherals that can be parked. There are four modes: run, wait, doze and stop. In run, all domains are clocked. Each low-power mode gates a different set of domains. Stop is the deepest mode and gates every domain.

The core enters a low-power mode by issuing an enter command with a 2-bit target code. Interrupt requests bring it back to run. Internal requests, raised by on-chip peripherals, and external requests arrive on separate inputs. Which of them may wake the block depends on the current mode. Only an external request can wake the block from stop, because the internal sources have no clock in that mode. Wake-up takes no extra delay: the clocks are enabled again in the cycle after the wake condition is seen. The enables are decoded from the registered mode, so they change at the same moment as the mode output.

Top module: `pwr_mode_gater`

## Requirements
- R1: While reset is asserted and after it is released, the mode output reads run (code 00) and every clock enable is 1.
- R2: In run, an enter command with target code 01, 10 or 11 sets the mode output to wait (01), doze (10) or stop (11) on the next clock edge.
- R3: An enter command with target code 00 is ignored, and the block stays in run.
- R4: An enter command received while the mode is not run has no effect on the mode.
- R5: In wait, the core and memory enables are 0, and all always-on and dozable peripheral enables are 1.
- R6: In doze, the core and memory enables are 0, the always-on peripheral enables are 1, and the dozable peripheral enables are 0.
- R7: In stop, every clock enable is 0.
- R8: In run, every clock enable is 1.
- R9: In wait or doze, any asserted bit of the internal or external interrupt inputs returns the block to run on the next edge, and all enables are 1 from that cycle on.
- R10: In stop, internal interrupt requests are ignored, and only an asserted external interrupt bit returns the block to run on the next edge.
- R11: When a wake condition and an enter command arrive in the same cycle while the block is in a low-power mode, the wake takes effect, the command is dropped, and the block ends in run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock of the controller |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Enter command strobe, one cycle per command |
| cmd_target | input | 2 | Target code of the command: 01 wait, 10 doze, 11 stop, 00 invalid |
| int_irq | input | N_INT | Internal peripheral interrupt requests |
| ext_irq | input | N_EXT | External interrupt requests |
| cpu_clk_en | output | 1 | Clock enable of the CPU core |
| mem_clk_en | output | 1 | Clock enable of the memory |
| aon_clk_en | output | N_AON | Clock enables of the always-on peripherals |
| dozable_clk_en | output | N_DOZE | Clock enables of the dozable peripherals |
| mode_o | output | 2 | Current mode: 00 run, 01 wait, 10 doze, 11 stop |

## Verification
Two events can fall in the same cycle: a wake request and an enter command, which can both reach the mode register while the block is in a low-power mode. The bench places the block in each mode and then applies, in one cycle, every combination of internal and external interrupt bits together with each target code or no command. The expected next mode is worked out arithmetically from the mode's wake rule and the command rule. The bench accepts the result only if the wake has won, or, where no wake was allowed, only if the mode is unchanged despite the command. The same sweep started in run shows that interrupts there do not disturb the handling of a command.

// File: rtl/pmg_pkg.sv
`timescale 1ns/1ps
package pmg_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_WAIT = 2'd1,
    MODE_DOZE = 2'd2,
    MODE_STOP = 2'd3
  } pm_mode_e;

  // a target code names a low-power mode only when it is non-zero
  function automatic logic target_ok(input logic [1:0] tgt);
    return tgt != 2'd0;
  endfunction

  // which requests may end the given mode
  function automatic logic wake_ok(input pm_mode_e m, input logic any_int,
                                   input logic any_ext);
    case (m)
      MODE_WAIT, MODE_DOZE: return any_int | any_ext;
      MODE_STOP:            return any_ext;
      default:              return 1'b0;
    endcase
  endfunction

  function automatic logic core_on(input pm_mode_e m);
    return m == MODE_RUN;
  endfunction

  function automatic logic aon_on(input pm_mode_e m);
    return m != MODE_STOP;
  endfunction

  function automatic logic dozable_on(input pm_mode_e m);
    return (m == MODE_RUN) || (m == MODE_WAIT);
  endfunction

endpackage

// File: rtl/pmg_cmd_decode.sv
`timescale 1ns/1ps
module pmg_cmd_decode
  import pmg_pkg::*;
(
  input  pm_mode_e   mode,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_target,
  output logic       enter_req,
  output pm_mode_e   enter_mode
);
  // only a running core can issue a usable enter command
  assign enter_req  = cmd_valid && (mode == MODE_RUN) && target_ok(cmd_target);
  assign enter_mode = pm_mode_e'(cmd_target);
endmodule

// File: rtl/pmg_wake_filter.sv
`timescale 1ns/1ps
module pmg_wake_filter
  import pmg_pkg::*;
#(
  parameter int N_INT = 4,
  parameter int N_EXT = 2
) (
  input  pm_mode_e         mode,
  input  logic [N_INT-1:0] int_irq,
  input  logic [N_EXT-1:0] ext_irq,
  output logic             wake
);
  logic any_int, any_ext;
  assign any_int = |int_irq;
  assign any_ext = |ext_irq;
  assign wake    = wake_ok(mode, any_int, any_ext);
endmodule

// File: rtl/pmg_domain_gate.sv
`timescale 1ns/1ps
module pmg_domain_gate
  import pmg_pkg::*;
#(
  parameter int N_AON  = 3,
  parameter int N_DOZE = 3
) (
  input  pm_mode_e          mode,
  output logic              cpu_en,
  output logic              mem_en,
  output logic [N_AON-1:0]  aon_en,
  output logic [N_DOZE-1:0] doze_en
);
  logic core_lvl, aon_lvl, doze_lvl;
  assign core_lvl = core_on(mode);
  assign aon_lvl  = aon_on(mode);
  assign doze_lvl = dozable_on(mode);

  assign cpu_en = core_lvl;
  assign mem_en = core_lvl;

  for (genvar a = 0; a < N_AON; a++) begin : g_aon
    assign aon_en[a] = aon_lvl;
  end
  for (genvar d = 0; d < N_DOZE; d++) begin : g_doze
    assign doze_en[d] = doze_lvl;
  end
endmodule

// File: rtl/pwr_mode_gater.sv
`timescale 1ns/1ps
module pwr_mode_gater
  import pmg_pkg::*;
#(
  parameter int N_INT  = 4,
  parameter int N_EXT  = 2,
  parameter int N_AON  = 3,
  parameter int N_DOZE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_target,
  input  logic [N_INT-1:0]  int_irq,
  input  logic [N_EXT-1:0]  ext_irq,
  output logic              cpu_clk_en,
  output logic              mem_clk_en,
  output logic [N_AON-1:0]  aon_clk_en,
  output logic [N_DOZE-1:0] dozable_clk_en,
  output logic [1:0]        mode_o
);
  pm_mode_e mode_q;
  logic     wake_evt;
  logic     enter_evt;
  pm_mode_e enter_mode;

  pmg_cmd_decode u_cmd (
    .mode       (mode_q),
    .cmd_valid  (cmd_valid),
    .cmd_target (cmd_target),
    .enter_req  (enter_evt),
    .enter_mode (enter_mode)
  );

  pmg_wake_filter #(.N_INT(N_INT), .N_EXT(N_EXT)) u_wake (
    .mode    (mode_q),
    .int_irq (int_irq),
    .ext_irq (ext_irq),
    .wake    (wake_evt)
  );

  // wake is listed first: the two events cannot coincide, but a wake is never lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_q <= MODE_RUN;
    else if (wake_evt)  mode_q <= MODE_RUN;
    else if (enter_evt) mode_q <= enter_mode;
  end

  pmg_domain_gate #(.N_AON(N_AON), .N_DOZE(N_DOZE)) u_gate (
    .mode    (mode_q),
    .cpu_en  (cpu_clk_en),
    .mem_en  (mem_clk_en),
    .aon_en  (aon_clk_en),
    .doze_en (dozable_clk_en)
  );

  assign mode_o = mode_q;

  AST_ENTER_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RUN && cmd_valid && cmd_target != 2'd0) |=> (mode_o == $past(cmd_target))); // R2
  AST_BAD_TARGET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RUN && cmd_valid && cmd_target == 2'd0) |=> (mode_o == 2'd0)); // R3
  AST_LP_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_RUN && cmd_valid && int_irq == '0 && ext_irq == '0) |=> $stable(mode_o)); // R4
  AST_WAIT_DOMAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1) |-> (!cpu_clk_en && !mem_clk_en && (&aon_clk_en) && (&dozable_clk_en))); // R5
  AST_DOZE_DOMAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2) |-> (!cpu_clk_en && !mem_clk_en && (&aon_clk_en) && dozable_clk_en == '0)); // R6
  AST_STOP_DOMAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd3) |-> (!cpu_clk_en && !mem_clk_en && aon_clk_en == '0 && dozable_clk_en == '0)); // R7
  AST_RUN_DOMAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0) |-> (cpu_clk_en && mem_clk_en && (&aon_clk_en) && (&dozable_clk_en))); // R8
  AST_WAKE_SHALLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_WAIT || mode_q == MODE_DOZE) && (int_irq != '0 || ext_irq != '0))
    |=> (mode_o == 2'd0 && cpu_clk_en)); // R9
  AST_STOP_INT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STOP && ext_irq == '0) |=> (mode_o == 2'd3)); // R10
  AST_STOP_EXT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STOP && ext_irq != '0) |=> (mode_o == 2'd0)); // R10
  AST_WAKE_BEATS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_RUN && wake_evt && cmd_valid) |=> (mode_o == 2'd0)); // R11
  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wake_evt && enter_evt)); // R11

endmodule

// File: tb/pwr_mode_gater_tb.sv
`timescale 1ns/1ps
module pwr_mode_gater_tb;
  localparam int N_INT  = 4;
  localparam int N_EXT  = 2;
  localparam int N_AON  = 3;
  localparam int N_DOZE = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cmd_valid;
  logic [1:0]        cmd_target;
  logic [N_INT-1:0]  int_irq;
  logic [N_EXT-1:0]  ext_irq;
  logic              cpu_clk_en, mem_clk_en;
  logic [N_AON-1:0]  aon_clk_en;
  logic [N_DOZE-1:0] dozable_clk_en;
  logic [1:0]        mode_o;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  pwr_mode_gater #(.N_INT(N_INT), .N_EXT(N_EXT), .N_AON(N_AON), .N_DOZE(N_DOZE)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_target(cmd_target),
    .int_irq(int_irq), .ext_irq(ext_irq), .cpu_clk_en(cpu_clk_en),
    .mem_clk_en(mem_clk_en), .aon_clk_en(aon_clk_en),
    .dozable_clk_en(dozable_clk_en), .mode_o(mode_o)
  );

  // packed enables: {cpu, mem, aon[2:0], doze[2:0]}
  function automatic int exp_en(input int m);
    int core = (m == 0) ? 1 : 0;
    int aon  = (m < 3) ? 7 : 0;
    int dz   = (m < 2) ? 7 : 0;
    return (core << 7) | (core << 6) | (aon << 3) | dz;
  endfunction

  function automatic int act_en();
    return {24'd0, cpu_clk_en, mem_clk_en, aon_clk_en, dozable_clk_en};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_inputs();
    cmd_valid = 1'b0; cmd_target = 2'd0; int_irq = '0; ext_irq = '0;
  endtask

  task automatic pulse_reset();
    @(negedge clk); clear_inputs(); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  function automatic string dom_tag(input int m);
    case (m)
      1: return "R5";
      2: return "R6";
      3: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    rst_n = 1'b0;
    clear_inputs();
    repeat (2) @(negedge clk);
    check(mode_o == 2'd0, "R1", mode_o, 0);
    check(act_en() == exp_en(0), "R1", act_en(), exp_en(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(mode_o == 2'd0, "R1", mode_o, 0);
    check(act_en() == exp_en(0), "R1", act_en(), exp_en(0));

    for (int start = 0; start < 4; start++) begin
      for (int pat = 0; pat < 64; pat++) begin
        for (int c = 0; c < 5; c++) begin
          int    exp_mode;
          bit    wake;
          string tag;
          logic [3:0] iv;
          logic [1:0] ev;
          pulse_reset();
          if (start != 0) begin
            cmd_valid = 1'b1; cmd_target = start[1:0];
            @(negedge clk);
            clear_inputs();
            check(mode_o == start[1:0], "R2", mode_o, start);
            check(act_en() == exp_en(start), dom_tag(start), act_en(), exp_en(start));
          end
          iv = pat[3:0];
          ev = pat[5:4];
          int_irq = iv; ext_irq = ev;
          cmd_valid  = (c < 4);
          cmd_target = c[1:0];
          @(negedge clk);
          clear_inputs();
          if (start == 0) begin
            wake     = 1'b0;
            exp_mode = (c < 4 && c != 0) ? c : 0;
            tag      = (c == 0) ? "R3" : "R2";
          end else begin
            wake     = (ev != 0) || (start != 3 && iv != 0);
            exp_mode = wake ? 0 : start;
            if (wake && c < 4)                tag = "R11";
            else if (start == 3 && iv != 0)   tag = "R10";
            else if (wake)                    tag = (start == 3) ? "R10" : "R9";
            else                              tag = "R4";
          end
          check(mode_o == exp_mode[1:0], tag, mode_o, exp_mode);
          check(act_en() == exp_en(exp_mode), (exp_mode == 0) ? "R8" : dom_tag(exp_mode),
                act_en(), exp_en(exp_mode));
        end
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule